// File: doc/BRIEF.md
# Ordered Dither Unit

This unit reduces the color depth of each RGB channel before the pixel goes to a flat panel. It applies an 8x8 ordered dither. A mode code selects how many low bits are removed from every 8-bit component: 1, 2, 3, 4 or 6. The removed bits are compared against a per-position threshold to decide whether the remaining upper part is rounded up by one. The position is the pixel's place in the repeating 8x8 tile, taken from the low bits of the horizontal and vertical pixel counters.

A single 64-entry rank matrix sets the order in which tile cells switch on. It is built from the recursive Bayer construction, and all truncation widths share it. With fewer removed bits, each step of the removed value switches on a larger group of cells. All three channels use the cell of the same pixel, but each channel is rounded on its own.

The result is registered once, with a valid flag. The mode is sampled only on a frame-start strobe, so a panel never sees a mode change in the middle of a frame.

Top module: `odither_core`

## Requirements
- R1: `mode_sel` codes 1, 2, 3, 4 and 6 remove that many low bits from each channel. Codes 0, 5 and 7 are bypass: the 8-bit pixel passes through unchanged.
- R2: With n bits removed, the output holds the rounded upper part right-aligned in bits [7-n:0]. The bits above are zero.
- R3: Only `x_cnt[2:0]` and `y_cnt[2:0]` select the tile cell. Higher counter bits have no effect on the output.
- R4: The rank of cell (x,y) is the 6-bit value whose bits, from MSB to LSB, are x0^y0, y0, x1^y1, y1, x2^y2, y2.
- R5: Let L be the removed low value. A channel is rounded up exactly when rank(x,y) < (L << (6-n)).
- R6: Rounding saturates. If the kept part is already all ones, it stays all ones.
- R7: In 1-bit mode, an LSB of 0 never rounds up. An LSB of 1 rounds up exactly on the cells where x0^y0 = 0, which forms a checkerboard.
- R8: The R, G and B channels are rounded independently, each from its own removed bits, all against the same cell rank.
- R9: The mode is loaded from `mode_sel` in any cycle where `frame_start` is 1, and it already applies to the pixel in that cycle. In all other cycles the stored mode is held.
- R10: `out_valid` equals `in_valid` of the previous clock. The output channels update only on a valid input and otherwise hold their value.
- R11: After reset, `out_valid` and all output channels are 0, and the stored mode is bypass (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Loads `mode_sel` as the active mode |
| mode_sel | input | 3 | Truncation mode code |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | CH_W | Red component |
| in_g | input | CH_W | Green component |
| in_b | input | CH_W | Blue component |
| x_cnt | input | CNT_W | Horizontal pixel counter |
| y_cnt | input | CNT_W | Vertical pixel counter |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | CH_W | Reduced red, right-aligned |
| out_g | output | CH_W | Reduced green, right-aligned |
| out_b | output | CH_W | Reduced blue, right-aligned |

## Verification
The bench builds the unit with its defaults: 8-bit channels, an 8x8 tile and 11-bit counters. The 11-bit counters let it set high counter bits and show that they leave the cell choice unchanged. At 6-bit truncation the removed value spans the full rank range, so a sweep over all 64 cells places each cell's rank just below and just at its threshold, which pins down the whole matrix. The 1-bit sweep checks the exact checkerboard. Vectors with an all-ones upper part reach the saturation corner in the 4-bit and 1-bit modes.

// File: rtl/odith_pkg.sv
package odith_pkg;

    typedef enum logic [2:0] {
        MODE_BYPASS = 3'd0,
        MODE_CUT1   = 3'd1,
        MODE_CUT2   = 3'd2,
        MODE_CUT3   = 3'd3,
        MODE_CUT4   = 3'd4,
        MODE_CUT6   = 3'd6
    } cut_mode_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/odith_width_decode.sv
module odith_width_decode
    import odith_pkg::*;
#(
    parameter int TW_W = 4
) (
    input  logic [MODE_W-1:0] mode_i,
    output logic [TW_W-1:0]   cut_o
);
    always_comb begin
        case (mode_i)
            MODE_CUT1, MODE_CUT2, MODE_CUT3,
            MODE_CUT4, MODE_CUT6: cut_o = TW_W'(mode_i);
            default:              cut_o = '0;
        endcase
    end
endmodule

// File: rtl/odith_rank.sv
module odith_rank #(
    parameter int TILE_LOG2 = 3,
    localparam int RANK_W = 2 * TILE_LOG2
) (
    input  logic [TILE_LOG2-1:0] x_i,
    input  logic [TILE_LOG2-1:0] y_i,
    output logic [RANK_W-1:0]    rank_o
);
    // Recursive Bayer order: the lowest coordinate bits form the rank MSBs.
    for (genvar lvl = 0; lvl < TILE_LOG2; lvl++) begin : g_level
        assign rank_o[RANK_W-1-2*lvl] = x_i[lvl] ^ y_i[lvl];
        assign rank_o[RANK_W-2-2*lvl] = y_i[lvl];
    end
endmodule

// File: rtl/odith_channel.sv
module odith_channel #(
    parameter int CH_W = 8,
    parameter int RANK_W = 6,
    parameter int TW_W = 4
) (
    input  logic [CH_W-1:0]   pix_i,
    input  logic [TW_W-1:0]   cut_i,
    input  logic [RANK_W-1:0] rank_i,
    output logic [CH_W-1:0]   pix_o
);
    localparam logic [TW_W-1:0] RANK_WN = TW_W'(RANK_W);

    logic [CH_W-1:0]   low_mask;
    logic [CH_W-1:0]   low_bits;
    logic [CH_W-1:0]   kept;
    logic [CH_W-1:0]   kept_max;
    logic [TW_W-1:0]   shamt;
    logic [RANK_W:0]   thresh;
    logic              bump;

    always_comb begin
        low_mask = (CH_W'(1) << cut_i) - CH_W'(1);
        low_bits = pix_i & low_mask;
        kept     = pix_i >> cut_i;
        kept_max = {CH_W{1'b1}} >> cut_i;
        shamt    = RANK_WN - cut_i;
        thresh   = (RANK_W+1)'(low_bits) << shamt;
        bump     = ({1'b0, rank_i} < thresh) && (kept != kept_max);
        pix_o    = bump ? kept + CH_W'(1) : kept;
    end

    always_comb begin
        AST_SAT_RANGE: assert (pix_o <= kept_max); // R6
        AST_BYPASS_EXACT: assert ((cut_i != '0) || (pix_o == pix_i)); // R1
    end
endmodule

// File: rtl/odither_core.sv
module odither_core
    import odith_pkg::*;
#(
    parameter int CH_W      = 8,
    parameter int TILE_LOG2 = 3,
    parameter int CNT_W     = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic [MODE_W-1:0]    mode_sel,
    input  logic                 in_valid,
    input  logic [CH_W-1:0]      in_r,
    input  logic [CH_W-1:0]      in_g,
    input  logic [CH_W-1:0]      in_b,
    input  logic [CNT_W-1:0]     x_cnt,
    input  logic [CNT_W-1:0]     y_cnt,
    output logic                 out_valid,
    output logic [CH_W-1:0]      out_r,
    output logic [CH_W-1:0]      out_g,
    output logic [CH_W-1:0]      out_b
);
    localparam int RANK_W = 2 * TILE_LOG2;
    localparam int TW_W   = $clog2(CH_W + 1);
    localparam int NCH    = 3;

    typedef struct packed {
        logic [MODE_W-1:0]          mode;
        logic                       vld;
        logic [NCH-1:0][CH_W-1:0]   pix;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [MODE_W-1:0]          mode_eff;
    logic [TW_W-1:0]            cut_w;
    logic [RANK_W-1:0]          rank_w;
    logic [NCH-1:0][CH_W-1:0]   pix_in;
    logic [NCH-1:0][CH_W-1:0]   pix_red;
    logic                       unused_cnt_hi;

    assign unused_cnt_hi = ^{x_cnt[CNT_W-1:TILE_LOG2], y_cnt[CNT_W-1:TILE_LOG2]};
    assign mode_eff = frame_start ? mode_sel : st_q.mode;
    assign pix_in   = {in_b, in_g, in_r};

    odith_width_decode #(.TW_W(TW_W)) u_decode (
        .mode_i (mode_eff),
        .cut_o  (cut_w)
    );

    odith_rank #(.TILE_LOG2(TILE_LOG2)) u_rank (
        .x_i    (x_cnt[TILE_LOG2-1:0]),
        .y_i    (y_cnt[TILE_LOG2-1:0]),
        .rank_o (rank_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        odith_channel #(
            .CH_W   (CH_W),
            .RANK_W (RANK_W),
            .TW_W   (TW_W)
        ) u_chan (
            .pix_i  (pix_in[c]),
            .cut_i  (cut_w),
            .rank_i (rank_w),
            .pix_o  (pix_red[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (frame_start) st_d.mode = mode_sel;
        if (in_valid)    st_d.pix  = pix_red;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_r     = st_q.pix[0];
    assign out_g     = st_q.pix[1];
    assign out_b     = st_q.pix[2];

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R10
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.mode)); // R9
endmodule

// File: tb/odither_core_tb.sv
module odither_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_r = '0, in_g = '0, in_b = '0;
    logic [10:0] x_cnt = '0, y_cnt = '0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    odither_core u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
        .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .x_cnt(x_cnt), .y_cnt(y_cnt),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [10:0] x;
        logic [10:0] y;
        logic [7:0]  pix;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd6, 11'd0,     11'd0,     8'h41, 8'h02, 8'd5},  // R5 rank 0 < 1
        '{3'd6, 11'd1,     11'd0,     8'h41, 8'h01, 8'd4},  // R4 rank 32
        '{3'd6, 11'd1,     11'd0,     8'h61, 8'h02, 8'd5},  // R5 32 < 33
        '{3'd4, 11'd0,     11'd0,     8'hF5, 8'h0F, 8'd6},  // R6 saturate
        '{3'd4, 11'd3,     11'd5,     8'h37, 8'h04, 8'd5},  // R5 27 < 28
        '{3'd4, 11'd3,     11'd5,     8'h36, 8'h03, 8'd5},  // R5 27 vs 24
        '{3'd3, 11'd2,     11'd0,     8'h81, 8'h10, 8'd5},  // R5 8 vs 8
        '{3'd3, 11'd0,     11'd0,     8'h81, 8'h11, 8'd2},  // R2 3-bit cut
        '{3'd2, 11'd2,     11'd2,     8'h42, 8'h11, 8'd5},  // R5 4 < 32
        '{3'd2, 11'd1,     11'd1,     8'h41, 8'h10, 8'd5},  // R5 16 vs 16
        '{3'd1, 11'd1,     11'd1,     8'h03, 8'h02, 8'd7},  // R7 even cell
        '{3'd1, 11'd1,     11'd0,     8'h03, 8'h01, 8'd7},  // R7 odd cell
        '{3'd1, 11'd7,     11'd7,     8'hFF, 8'h7F, 8'd6},  // R6 1-bit sat
        '{3'd0, 11'd0,     11'd0,     8'hA5, 8'hA5, 8'd1},  // R1 bypass 0
        '{3'd5, 11'd3,     11'd4,     8'h3C, 8'h3C, 8'd1},  // R1 code 5
        '{3'd7, 11'd0,     11'd0,     8'h01, 8'h01, 8'd1},  // R1 code 7
        '{3'd6, 11'h401,   11'h100,   8'h41, 8'h01, 8'd3},  // R3 high bits
        '{3'd6, 11'd7,     11'd7,     8'h15, 8'h00, 8'd4},  // R4 rank 21
        '{3'd6, 11'd7,     11'd7,     8'h16, 8'h01, 8'd4}   // R4 21 < 22
    };

    task automatic check(input int req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic fs, input logic v,
                         input logic [10:0] x, input logic [10:0] y,
                         input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        mode_sel = m; frame_start = fs; in_valid = v;
        x_cnt = x; y_cnt = y; in_r = r; in_g = g; in_b = b;
        @(negedge clk);
    endtask

    function automatic logic [5:0] tb_rank(input logic [2:0] x, input logic [2:0] y);
        return {x[0]^y[0], y[0], x[1]^y[1], y[1], x[2]^y[2], y[2]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(11, "reset out_valid", {7'd0, out_valid}, 8'h00);
        check(11, "reset out_r", out_r, 8'h00);
        check(11, "reset out_b", out_b, 8'h00);
        // R11: reset mode is bypass, no frame_start given
        drive(3'd6, 1'b0, 1'b1, 11'd0, 11'd0, 8'hA5, 8'hA5, 8'hA5);
        check(11, "reset mode bypass", out_r, 8'hA5);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, 1'b1, 1'b1, VECS[i].x, VECS[i].y,
                  VECS[i].pix, VECS[i].pix, VECS[i].pix);
            check(int'(VECS[i].req), $sformatf("vec %0d r", i), out_r, VECS[i].exp);
            check(int'(VECS[i].req), $sformatf("vec %0d g", i), out_g, VECS[i].exp);
            check(int'(VECS[i].req), $sformatf("vec %0d b", i), out_b, VECS[i].exp);
        end

        // R8: independent channels, same cell (rank 0)
        drive(3'd6, 1'b1, 1'b1, 11'd0, 11'd0, 8'h41, 8'h40, 8'hFF);
        check(8, "chan r", out_r, 8'h02);
        check(8, "chan g", out_g, 8'h01);
        check(8, "chan b", out_b, 8'h03);

        // R9: mode held without frame_start
        drive(3'd0, 1'b0, 1'b1, 11'd0, 11'd0, 8'h41, 8'h41, 8'h41);
        check(9, "mode held 6", out_r, 8'h02);
        drive(3'd0, 1'b1, 1'b1, 11'd0, 11'd0, 8'h41, 8'h41, 8'h41);
        check(9, "frame_start loads bypass", out_r, 8'h41);

        // R10: latency and hold
        drive(3'd0, 1'b0, 1'b0, 11'd0, 11'd0, 8'h12, 8'h34, 8'h56);
        check(10, "valid low", {7'd0, out_valid}, 8'h00);
        check(10, "data held", out_r, 8'h41);
        drive(3'd0, 1'b0, 1'b1, 11'd0, 11'd0, 8'h12, 8'h34, 8'h56);
        check(10, "valid high", {7'd0, out_valid}, 8'h01);
        check(10, "data updated", out_g, 8'h34);

        // R4/R5: full-tile rank sweep at 6-bit cut
        for (int y = 0; y < 8; y++) begin
            for (int x = 0; x < 8; x++) begin
                logic [5:0] rk;
                rk = tb_rank(3'(x), 3'(y));
                drive(3'd6, 1'b1, 1'b1, 11'(x), 11'(y),
                      {2'b01, rk}, {2'b01, rk}, {2'b01, rk});
                check(4, $sformatf("rank (%0d,%0d) at equal", x, y), out_r, 8'h01);
                if (rk != 6'd63) begin
                    drive(3'd6, 1'b1, 1'b1, 11'(x), 11'(y),
                          {2'b01, rk + 6'd1}, 8'h40, 8'h40);
                    check(5, $sformatf("rank (%0d,%0d) above", x, y), out_r, 8'h02);
                end
            end
        end

        // R7: 1-bit checkerboard sweep; R2 upper bits zero
        for (int y = 0; y < 8; y++) begin
            for (int x = 0; x < 8; x++) begin
                drive(3'd1, 1'b1, 1'b1, 11'(x), 11'(y), 8'h01, 8'h00, 8'h01);
                check(7, $sformatf("lsb1 (%0d,%0d)", x, y), out_r,
                      (((x ^ y) & 1) == 0) ? 8'h01 : 8'h00);
                check(7, $sformatf("lsb0 (%0d,%0d)", x, y), out_g, 8'h00);
            end
        end
        drive(3'd1, 1'b1, 1'b1, 11'd1, 11'd0, 8'hFE, 8'hFE, 8'hFE);
        check(2, "1-bit right-aligned", out_r, 8'h7F);

        finish_run();
    end
endmodule